// File: doc/BRIEF.md
# Nested Trap and Interrupt Arbiter

This block gathers trap requests raised by the core's own execution (faults such as overflow, division by zero or a bad memory reference) and interrupt requests from outside sources (timer, I/O controllers, failure monitors). Each cycle it picks the one request the core should take next and presents it as a registered valid flag with a binary source index. The core answers with an entry strobe when it starts the handler and a return strobe when the handler ends.

Two service disciplines are available and can be switched at run time. In sequential mode, nothing is presented while any handler is running. In nested mode, a request may preempt the running handler only if its level is strictly above the level of that handler. Levels in service are held in a small last-in, first-out stack, so preempted handlers resume in reverse order of entry. Every acceptance drops the processor mode bit to privileged. The core raises it back to user mode with a separate strobe.

Interrupt lines pass through a two-flop synchroniser and are level-sensitive. Traps arrive already synchronous and are not synchronised. A global enable gates interrupts only.

Top module: `trap_irq_arbiter`

## Requirements
- R1: After reset, `pres_valid_o`, `busy_o` and `cur_lvl_o` are 0, and `mode_user_o` is 0, which means privileged mode.
- R2: Trap inputs take source indices 0 to N_TRAP-1. Interrupt k takes index N_TRAP+k. Every trap has level 2**LVL_W, which is above any programmable interrupt level, so a pending trap wins over any pending interrupt.
- R3: Among eligible requests, the one with the highest level is presented. When levels are equal, the lowest source index wins.
- R4: With `ie_i` at 0, no interrupt is presented, but traps still are.
- R5: A trap raised before a clock edge is presented after that edge. An interrupt is presented after the third edge, because it first passes the two synchroniser flops.
- R6: Requests are level-sensitive. A request that is withdrawn before entry stops being presented on the same schedule as R5.
- R7: An `entry_i` pulse while `pres_valid_o` is 1 accepts the request: its level is pushed, `busy_o` rises and the mode turns privileged. Any `entry_i` or `ret_i` pulse clears `pres_valid_o` for the next cycle. `entry_i` with nothing presented is ignored.
- R8: `set_user_i` sets `mode_user_o` to 1 unless an acceptance happens in the same cycle, in which case the mode is privileged.
- R9: In sequential mode (`nest_en_i`=0), nothing is presented while `busy_o` is 1, and this includes traps.
- R10: In nested mode, while a handler is running, only requests with a level strictly greater than `cur_lvl_o` are presented. `cur_lvl_o` is the level on top of the stack, or 0 when idle.
- R11: `ret_i` pops the top level, so `cur_lvl_o` returns to the handler that was preempted. `ret_i` with an empty stack is ignored.
- R12: When STACK_DEPTH levels are in service, nothing is presented, including traps.
- R13: When `entry_i` (with a presentation) and `ret_i` fall in the same cycle, the top level is replaced by the accepted level and the depth stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_i | input | N_TRAP | Synchronous trap requests, level-sensitive |
| irq_i | input | N_IRQ | Asynchronous interrupt requests, level-sensitive |
| irq_prio_i | input | N_IRQ*LVL_W | Level of each interrupt, field k at bits k*LVL_W upward |
| ie_i | input | 1 | Global interrupt enable (does not gate traps) |
| nest_en_i | input | 1 | 1 selects nested preemption, 0 selects sequential masking |
| entry_i | input | 1 | Core strobe: handler for the presented request starts |
| ret_i | input | 1 | Core strobe: current handler returns |
| set_user_i | input | 1 | Core strobe: switch to user mode |
| pres_valid_o | output | 1 | A request is presented |
| pres_vec_o | output | $clog2(N_TRAP+N_IRQ) | Index of the presented source |
| mode_user_o | output | 1 | 1 means user mode, 0 means privileged mode |
| busy_o | output | 1 | At least one handler is in service |
| cur_lvl_o | output | LVL_W+1 | Level of the innermost handler, 0 when idle |

## Verification
The entry and return strobes can land in the same cycle, and they then act on the in-service stack together: the return frees the top slot and the entry fills it again. The directed part fills the stack to its limit, pops one level and accepts a trap with both strobes at once. It then judges the result from `cur_lvl_o` right after, and again after one further return, which must reveal the level that was below the replaced one. The random part raises both strobes independently. A bench model predicts the stack, mode and presentation every cycle, which also covers a user-mode request that coincides with an acceptance.

// File: rtl/tia_pkg.sv
package tia_pkg;

  typedef enum logic {
    MODE_PRIV = 1'b0,
    MODE_USER = 1'b1
  } tia_mode_e;

  // index width that never collapses to zero
  function automatic int unsigned tia_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tia_sync2.sv
module tia_sync2 #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/tia_pick.sv
module tia_pick #(
  parameter int unsigned N   = 8,
  parameter int unsigned LVW = 4,
  parameter int unsigned VW  = 3
) (
  input  logic [N-1:0]     req,
  input  logic [N*LVW-1:0] lvl,
  output logic             hit,
  output logic [VW-1:0]    idx,
  output logic [LVW-1:0]   best
);

  // ascending scan, strict compare: ties keep the lowest index
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!hit || (lvl[i*LVW +: LVW] > best))) begin
        hit  = 1'b1;
        idx  = VW'(i);
        best = lvl[i*LVW +: LVW];
      end
    end
  end

endmodule

// File: rtl/tia_lifo.sv
module tia_lifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               top,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       full
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          do_pop;
  logic          do_push;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] top_idx;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
  assign top_idx = AW'(cnt_q - CW'(1));
  assign wr_idx  = do_pop ? top_idx : AW'(cnt_q);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (do_push && !do_pop) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (do_pop && !do_push) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign top  = (cnt_q == '0) ? '0 : mem[top_idx];
  assign cnt  = cnt_q;
  assign full = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
  import tia_pkg::*;
#(
  parameter int unsigned N_TRAP      = 2,
  parameter int unsigned N_IRQ       = 6,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned STACK_DEPTH = 4
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [N_TRAP-1:0]                       trap_i,
  input  logic [N_IRQ-1:0]                        irq_i,
  input  logic [N_IRQ*LVL_W-1:0]                  irq_prio_i,
  input  logic                                    ie_i,
  input  logic                                    nest_en_i,
  input  logic                                    entry_i,
  input  logic                                    ret_i,
  input  logic                                    set_user_i,
  output logic                                    pres_valid_o,
  output logic [tia_idx_w(N_TRAP+N_IRQ)-1:0]      pres_vec_o,
  output logic                                    mode_user_o,
  output logic                                    busy_o,
  output logic [LVL_W:0]                          cur_lvl_o
);

  localparam int unsigned N_SRC = N_TRAP + N_IRQ;
  localparam int unsigned VW    = tia_idx_w(N_SRC);
  localparam int unsigned LVW   = LVL_W + 1;
  localparam int unsigned CW    = $clog2(STACK_DEPTH + 1);
  localparam logic [LVW-1:0] TRAP_LVL = {1'b1, {LVL_W{1'b0}}};

  logic [N_IRQ-1:0]     irq_s;
  logic [N_SRC-1:0]     src_req;
  logic [N_SRC*LVW-1:0] src_lvl;
  logic [N_SRC-1:0]     elig;
  logic                 pick_hit;
  logic [VW-1:0]        pick_idx;
  logic [LVW-1:0]       pick_lvl;
  logic [LVW-1:0]       lifo_top;
  logic [CW-1:0]        lifo_cnt;
  logic                 lifo_full;
  logic                 lifo_busy;
  logic                 accept;

  logic                 pres_valid_q;
  logic [VW-1:0]        pres_vec_q;
  logic [LVW-1:0]       pres_lvl_q;
  tia_mode_e            mode_q;

  tia_sync2 #(.W(N_IRQ)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_i),
    .q   (irq_s)
  );

  // traps: fixed top level, not gated by the global enable
  for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
    assign src_req[t]               = trap_i[t];
    assign src_lvl[t*LVW +: LVW]    = TRAP_LVL;
  end

  // interrupts: programmed level, gated by the global enable
  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    assign src_req[N_TRAP+k]            = irq_s[k] & ie_i;
    assign src_lvl[(N_TRAP+k)*LVW +: LVW] = {1'b0, irq_prio_i[k*LVL_W +: LVL_W]};
  end

  // eligibility against the service discipline and stack state
  for (genvar s = 0; s < N_SRC; s++) begin : g_elig
    assign elig[s] = src_req[s] && !lifo_full &&
                     (!lifo_busy || (nest_en_i && (src_lvl[s*LVW +: LVW] > lifo_top)));
  end

  tia_pick #(.N(N_SRC), .LVW(LVW), .VW(VW)) u_pick (
    .req  (elig),
    .lvl  (src_lvl),
    .hit  (pick_hit),
    .idx  (pick_idx),
    .best (pick_lvl)
  );

  assign accept = entry_i && pres_valid_q;

  tia_lifo #(.DEPTH(STACK_DEPTH), .W(LVW)) u_lifo (
    .clk  (clk),
    .rst  (rst),
    .push (accept),
    .pop  (ret_i),
    .din  (pres_lvl_q),
    .top  (lifo_top),
    .cnt  (lifo_cnt),
    .full (lifo_full)
  );

  assign lifo_busy = (lifo_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_valid_q <= 1'b0;
      pres_vec_q   <= '0;
      pres_lvl_q   <= '0;
    end else begin
      // one-cycle bubble after any core strobe: the stack top is moving
      pres_valid_q <= pick_hit && !(entry_i || ret_i);
      pres_vec_q   <= pick_idx;
      pres_lvl_q   <= pick_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PRIV;
    end else if (accept) begin
      mode_q <= MODE_PRIV;
    end else if (set_user_i) begin
      mode_q <= MODE_USER;
    end
  end

  assign pres_valid_o = pres_valid_q;
  assign pres_vec_o   = pres_vec_q;
  assign mode_user_o  = (mode_q == MODE_USER);
  assign busy_o       = lifo_busy;
  assign cur_lvl_o    = lifo_top;

endmodule

// File: rtl/trap_irq_arbiter_chk.sv
module trap_irq_arbiter_chk #(
  parameter int unsigned VW     = 3,
  parameter int unsigned LVW    = 4,
  parameter int unsigned CW     = 3,
  parameter int unsigned N_TRAP = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           ie_i,
  input logic           nest_en_i,
  input logic           entry_i,
  input logic           ret_i,
  input logic           set_user_i,
  input logic           pres_valid_o,
  input logic [VW-1:0]  pres_vec_o,
  input logic           mode_user_o,
  input logic           busy_o,
  input logic [LVW-1:0] cur_lvl_o,
  input logic [LVW-1:0] pres_lvl,
  input logic           lifo_full,
  input logic [CW-1:0]  lifo_cnt
);

  // R7
  accept_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_i && pres_valid_o) |=> !mode_user_o);

  // R7
  strobe_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_i || ret_i) |=> !pres_valid_o);

  // R8
  user_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_user_i && !(entry_i && pres_valid_o)) |=> mode_user_o);

  // R9
  seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !nest_en_i) |=> !pres_valid_o);

  // R10
  nest_higher_chk: assert property (@(posedge clk) disable iff (rst)
    (pres_valid_o && busy_o) |-> (pres_lvl > cur_lvl_o));

  // R12
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    lifo_full |=> !pres_valid_o);

  // R4
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (pres_valid_o && (pres_vec_o >= VW'(N_TRAP))) |-> $past(ie_i));

  // R11
  pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !entry_i && busy_o) |=> (lifo_cnt == $past(lifo_cnt) - CW'(1)));

endmodule

bind trap_irq_arbiter trap_irq_arbiter_chk #(
  .VW(VW), .LVW(LVW), .CW(CW), .N_TRAP(N_TRAP)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ie_i         (ie_i),
  .nest_en_i    (nest_en_i),
  .entry_i      (entry_i),
  .ret_i        (ret_i),
  .set_user_i   (set_user_i),
  .pres_valid_o (pres_valid_o),
  .pres_vec_o   (pres_vec_o),
  .mode_user_o  (mode_user_o),
  .busy_o       (busy_o),
  .cur_lvl_o    (cur_lvl_o),
  .pres_lvl     (pres_lvl_q),
  .lifo_full    (lifo_full),
  .lifo_cnt     (lifo_cnt)
);

// File: tb/trap_irq_arbiter_bench.sv
`timescale 1ns/1ps
module trap_irq_arbiter_bench;

  localparam int NT  = 2;
  localparam int NI  = 6;
  localparam int LW  = 3;
  localparam int DEP = 4;
  localparam int TRAPL = 1 << LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NT-1:0]    trap  = '0;
  logic [NI-1:0]    irq   = '0;
  logic [NI*LW-1:0] prio  = {3'd3, 3'd5, 3'd5, 3'd1, 3'd6, 3'd2};
  logic ie = 1'b1, nest = 1'b0, entry = 1'b0, ret = 1'b0, su = 1'b0;

  logic       pv;
  logic [2:0] vec;
  logic       mu;
  logic       busy;
  logic [LW:0] cl;

  trap_irq_arbiter #(.N_TRAP(NT), .N_IRQ(NI), .LVL_W(LW), .STACK_DEPTH(DEP))
  u_trap_irq_arbiter (
    .clk(clk), .rst(rst), .trap_i(trap), .irq_i(irq), .irq_prio_i(prio),
    .ie_i(ie), .nest_en_i(nest), .entry_i(entry), .ret_i(ret), .set_user_i(su),
    .pres_valid_o(pv), .pres_vec_o(vec), .mode_user_o(mu), .busy_o(busy),
    .cur_lvl_o(cl)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [NI-1:0] m_s1, m_s2;
  int  m_stk [DEP];
  int  m_cnt;
  bit  m_pv;
  int  m_vec, m_lvl;
  bit  m_user;

  function automatic int lvl_of(input int s);
    if (s < NT) return TRAPL;
    return int'(prio[(s-NT)*LW +: LW]);
  endfunction

  function automatic int m_top();
    return (m_cnt > 0) ? m_stk[m_cnt-1] : 0;
  endfunction

  task automatic model_step();
    bit hit, acc, pop, rq;
    int bv, bl, top, l;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_cnt = 0; m_pv = 0; m_vec = 0; m_lvl = 0; m_user = 0;
    end else begin
      hit = 0; bv = 0; bl = 0; top = m_top();
      for (int s = 0; s < NT + NI; s++) begin
        rq = (s < NT) ? trap[s] : (m_s2[s-NT] && ie);
        l  = lvl_of(s);
        if (rq && m_cnt < DEP && (m_cnt == 0 || (nest && l > top)))
          if (!hit || l > bl) begin hit = 1; bv = s; bl = l; end
      end
      acc = entry && m_pv;
      pop = ret && (m_cnt > 0);
      if (acc && pop) m_stk[m_cnt-1] = m_lvl;
      else if (acc) begin m_stk[m_cnt] = m_lvl; m_cnt++; end
      else if (pop) m_cnt--;
      if (acc) m_user = 0;
      else if (su) m_user = 1;
      m_pv  = hit && !(entry || ret);
      m_vec = bv;
      m_lvl = bl;
      m_s2  = m_s1;
      m_s1  = irq;
    end
  endtask

  always @(posedge clk) model_step();

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic accept_one();
    entry = 1'b1; cyc(1); entry = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rst = 1'b0;
    chk("R1", "pres_valid", pv, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "mode_user", mu, 0);
    chk("R1", "cur_lvl", cl, 0);

    su = 1; cyc(1); su = 0;
    chk("R8", "mode_user after request", mu, 1);

    accept_one();
    chk("R7", "busy after stray entry", busy, 0);
    chk("R7", "mode after stray entry", mu, 1);

    trap = 2'b10; cyc(1);
    chk("R5", "trap presented", pv, 1);
    chk("R2", "trap index", vec, 1);
    trap = 2'b11; cyc(1);
    chk("R3", "tie lowest index", vec, 0);
    trap = 2'b00; cyc(1);
    chk("R6", "withdrawn trap", pv, 0);

    irq = 6'b010010; cyc(2);
    chk("R5", "irq not yet through sync", pv, 0);
    cyc(1);
    chk("R5", "irq presented", pv, 1);
    chk("R3", "highest level irq", vec, 3);

    ie = 0; cyc(1);
    chk("R4", "irq masked", pv, 0);
    trap = 2'b10; cyc(1);
    chk("R4", "trap ignores enable", vec, 1);
    chk("R4", "trap valid while masked", pv, 1);
    ie = 1; cyc(1);
    chk("R2", "trap over level-6 irq", vec, 1);
    trap = 2'b00; cyc(1);
    chk("R3", "irq back", vec, 3);

    accept_one();
    chk("R7", "bubble after entry", pv, 0);
    chk("R7", "busy", busy, 1);
    chk("R7", "cur_lvl", cl, 6);
    chk("R7", "mode privileged", mu, 0);

    cyc(2);
    chk("R9", "sequential hold", pv, 0);
    trap = 2'b01; cyc(1);
    chk("R9", "trap held in sequential", pv, 0);

    nest = 1; cyc(1);
    chk("R10", "trap preempts", pv, 1);
    chk("R10", "trap index", vec, 0);
    trap = 2'b00; cyc(1);
    chk("R10", "equal level waits", pv, 0);
    trap = 2'b01; cyc(1);
    su = 1; entry = 1; cyc(1); su = 0; entry = 0;
    chk("R8", "acceptance beats user request", mu, 0);
    chk("R7", "nested level", cl, 8);
    trap = 2'b00;

    ret = 1; cyc(1); ret = 0;
    chk("R11", "resume preempted", cl, 6);
    chk("R11", "still busy", busy, 1);
    cyc(1);
    chk("R10", "equal level still waits", pv, 0);
    ret = 1; cyc(1); ret = 0;
    chk("R11", "idle after last return", busy, 0);
    chk("R11", "idle level", cl, 0);
    ret = 1; cyc(1); ret = 0;
    chk("R11", "return on empty ignored", busy, 0);
    chk("R7", "bubble after return", pv, 0);
    cyc(1);
    chk("R3", "pending irq after idle", vec, 3);

    // fill the in-service stack with rising levels
    irq = 6'b000100; cyc(3);
    chk("R6", "withdrawn irqs gone", vec, 4);
    accept_one();
    chk("R10", "level 1 in service", cl, 1);
    irq = 6'b000101; cyc(3);
    chk("R10", "level 2 preempts 1", vec, 2);
    accept_one();
    irq = 6'b011101; cyc(3);
    chk("R3", "level-5 tie", vec, 5);
    accept_one();
    irq = 6'b011111; cyc(3);
    chk("R10", "level 6 preempts 5", vec, 3);
    accept_one();
    chk("R12", "depth at limit level", cl, 6);
    trap = 2'b01; cyc(2);
    chk("R12", "full blocks trap", pv, 0);

    ret = 1; cyc(1); ret = 0;
    chk("R11", "pop to level 5", cl, 5);
    cyc(1);
    chk("R10", "trap presented after pop", vec, 0);
    entry = 1; ret = 1; cyc(1); entry = 0; ret = 0;
    chk("R13", "top replaced", cl, 8);
    chk("R13", "still busy", busy, 1);
    trap = 2'b00;
    ret = 1; cyc(1); ret = 0;
    chk("R13", "depth kept, level below", cl, 2);

    // ---------------- random phase ----------------
    rst = 1; irq = '0; nest = 0; ie = 1; cyc(2); rst = 0;
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < NT; b++) if ($urandom % 12 == 0) trap[b] = ~trap[b];
      for (int b = 0; b < NI; b++) if ($urandom % 10 == 0) irq[b] = ~irq[b];
      if ($urandom % 40 == 0) nest = ~nest;
      if ($urandom % 30 == 0) ie = ~ie;
      entry = ($urandom % 3 == 0);
      ret   = ($urandom % 6 == 0);
      su    = ($urandom % 8 == 0);
      cyc(1);
      chk("R7", "random pres_valid", pv, int'(m_pv));
      if (m_pv) chk("R3", "random vector", vec, m_vec);
      chk("R8", "random mode", mu, int'(m_user));
      chk("R11", "random busy", busy, int'(m_cnt > 0));
      chk("R10", "random cur_lvl", cl, m_top());
    end
    entry = 0; ret = 0; su = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule